// File: doc/BRIEF.md
# Linear SVM Scoring and Decision Unit

This unit sits beside a small processor as a custom function unit and speeds up linear support-vector classification. The processor hands it one command per valid/ready handshake. A multiply command carries a 32-bit feature word and a 32-bit weight word. Eight signed 4x4 multipliers work on these words in parallel, and their sum is added into a 32-bit running accumulator. The same eight multipliers can be combined to form wider products, so one datapath covers 4-bit, 8-bit and 16-bit operands.

When all terms of one classifier have been accumulated, a score command hands the accumulated value to the decision stage and zeroes the accumulator. The decision stage works in one of two ways. In one-vs-rest mode it keeps the class with the highest score. In one-vs-one mode each pairwise score casts a single vote, for one of its two classes. A decide command then publishes the winning class. A clear command starts a new classification.

Top module: `svm_accel`

## Requirements
- R1: A command is taken on a rising edge where `cmdValid` and `cmdReady` are both high. `cmdReady` is low in the following cycle. It returns high after one busy cycle, or after two busy cycles for a multiply at 16-bit precision.
- R2: Command codes on `cmdOp` are 0 clear, 1 multiply, 2 score and 3 decide. At `precSel`=0 a multiply adds to the accumulator the sum of eight products. Each product is a signed 4-bit nibble `cmdFeat[4i+3:4i]` times the signed nibble `cmdWeight[4i+3:4i]`, for i = 0 to 7.
- R3: At `precSel`=1 a multiply adds the sum of two signed byte products: byte 0 times byte 0, and byte 1 times byte 1. Bits 31:16 of both words are ignored.
- R4: At `precSel`=2 or 3 a multiply adds one signed product, `cmdFeat[15:0]` times `cmdWeight[15:0]`. It is built in two passes of eight partial products.
- R5: The accumulator is 32 bits wide and wraps modulo 2^32. It reads zero after reset.
- R6: A clear command zeroes the accumulator, all vote counts and the one-vs-rest best score.
- R7: In a score command, the positive class is `cmdFeat[2:0]` and the negative class is `cmdFeat[6:4]`. The accumulator reads zero once the score command completes.
- R8: With `schemeSel`=0, decide reports the positive class with the highest score among those scored since the last clear. On equal scores the lower class index wins.
- R9: With `schemeSel`=1, a score of zero or above gives one vote to the positive class, and a negative score gives one vote to the negative class. Decide reports the class with the most votes; on equal votes the lower index wins.
- R10: `resultValid` rises in the cycle after a decide command is taken. It stays high with `resultClass` unchanged until the next command is taken, and then falls.
- R11: A command offered while `cmdReady` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Processor offers a command |
| cmdReady | output | 1 | Unit can take a command |
| cmdOp | input | 2 | Command code |
| cmdFeat | input | 32 | Feature word, or class fields for score |
| cmdWeight | input | 32 | Weight word |
| precSel | input | 2 | Operand precision select |
| schemeSel | input | 1 | 0 one-vs-rest, 1 one-vs-one |
| resultValid | output | 1 | Decision published |
| resultClass | output | CLS_W | Winning class index |
| accValue | output | 32 | Current accumulator value |

## Verification
Two things can fall in the same cycle. The first is a multiply still executing its pass. The second is the processor offering the next command while `cmdReady` is low. The bench provokes this case by switching to a clear command with valid held high during the busy cycle, then withdrawing it before the unit is ready again. It judges the result by checking that the accumulator still holds the multiply result. A second overlap is that taking a new command also retires the published result. This is judged by watching `resultValid` fall once a clear has been taken after a decide.

// File: rtl/svm_accel_pkg.sv
package svm_accel_pkg;
  typedef enum logic [1:0] {
    OP_CLEAR  = 2'd0,
    OP_MAC    = 2'd1,
    OP_SCORE  = 2'd2,
    OP_DECIDE = 2'd3
  } op_e;

  typedef struct packed {
    logic load;      // command taken this edge
    logic clear;
    logic mac;
    logic pass;      // second pass of a wide product
    logic wide;      // 16-bit operands
    logic byteMode;  // 8-bit operands
    logic score;
    logic decide;
  } ctrl_t;
endpackage

// File: rtl/svm_accel_ctrl.sv
module svm_accel_ctrl
  import svm_accel_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic [1:0] precSel,
  output logic       cmdReady,
  output ctrl_t      ctl
);
  typedef enum logic [1:0] {S_IDLE, S_EXEC, S_EXEC2} state_e;

  state_e state;
  op_e    opReg;
  logic   wideReg, byteReg, accept;

  assign cmdReady = (state == S_IDLE);
  assign accept   = cmdValid && cmdReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      opReg   <= OP_CLEAR;
      wideReg <= 1'b0;
      byteReg <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (accept) begin
          opReg   <= op_e'(cmdOp);
          wideReg <= precSel[1];
          byteReg <= !precSel[1] && precSel[0];
          state   <= S_EXEC;
        end
        S_EXEC:  state <= (opReg == OP_MAC && wideReg) ? S_EXEC2 : S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.load     = accept;
    ctl.clear    = (state == S_EXEC) && (opReg == OP_CLEAR);
    ctl.mac      = (state != S_IDLE) && (opReg == OP_MAC);
    ctl.pass     = (state == S_EXEC2);
    ctl.wide     = wideReg;
    ctl.byteMode = byteReg;
    ctl.score    = (state == S_EXEC) && (opReg == OP_SCORE);
    ctl.decide   = (state == S_EXEC) && (opReg == OP_DECIDE);
  end

  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdReady |=> !cmdReady);
  a_r1_wide_second_pass: assert property (@(posedge clk) disable iff (!rstN)
    ctl.mac && ctl.wide && !ctl.pass |=> !cmdReady && ctl.pass);
  a_r1_narrow_single: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.clear || ctl.score || ctl.decide || (ctl.mac && !ctl.wide)) |=> cmdReady);
endmodule

// File: rtl/svm_accel_dp.sv
module svm_accel_dp
  import svm_accel_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int CLS_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            ctl,
  input  logic [31:0]      cmdFeat,
  input  logic [31:0]      cmdWeight,
  output logic [ACC_W-1:0] acc,
  output logic [CLS_W-1:0] posCls,
  output logic [CLS_W-1:0] negCls
);
  localparam int LANES = 8;

  logic [31:0]      featReg, wtReg;
  logic [ACC_W-1:0] laneProd [LANES];
  logic [ACC_W-1:0] laneSum;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      featReg <= '0;
      wtReg   <= '0;
    end else if (ctl.load) begin
      featReg <= cmdFeat;
      wtReg   <= cmdWeight;
    end
  end

  assign posCls = featReg[CLS_W-1:0];
  assign negCls = featReg[4 +: CLS_W];

  for (genvar m = 0; m < LANES; m++) begin : g_lane
    logic [2:0]        aIdx, bIdx;
    logic              aSgn, bSgn;
    logic [4:0]        sh;
    logic [3:0]        aNib, bNib;
    logic signed [4:0] aExt, bExt;
    logic signed [9:0] prod;

    always_comb begin
      if (ctl.wide) begin
        aIdx = 3'(m % 4);
        bIdx = 3'(m / 4) + (ctl.pass ? 3'd2 : 3'd0);
        aSgn = (m % 4 == 3);
        bSgn = ctl.pass && (m / 4 == 1);
        sh   = {aIdx + bIdx, 2'b00};
      end else if (ctl.byteMode) begin
        aIdx = 3'(2 * (m / 4) + (m / 2) % 2);
        bIdx = 3'(2 * (m / 4) + m % 2);
        aSgn = ((m / 2) % 2 == 1);
        bSgn = (m % 2 == 1);
        sh   = 5'(4 * ((m / 2) % 2 + m % 2));
      end else begin
        aIdx = 3'(m);
        bIdx = 3'(m);
        aSgn = 1'b1;
        bSgn = 1'b1;
        sh   = 5'd0;
      end
      aNib = featReg[4*aIdx +: 4];
      bNib = wtReg[4*bIdx +: 4];
      aExt = signed'({aSgn & aNib[3], aNib});
      bExt = signed'({bSgn & bNib[3], bNib});
      prod = aExt * bExt;
      laneProd[m] = ACC_W'(prod) << sh;
    end
  end

  always_comb begin
    laneSum = '0;
    for (int i = 0; i < LANES; i++) laneSum += laneProd[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clear || ctl.score) acc <= '0;
    else if (ctl.mac)                    acc <= acc + laneSum;
  end

  a_r6_clear_zeroes_acc: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> acc == '0);
  a_r7_score_zeroes_acc: assert property (@(posedge clk) disable iff (!rstN)
    ctl.score |=> acc == '0);
  a_r11_acc_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.mac || ctl.clear || ctl.score) |=> $stable(acc));
endmodule

// File: rtl/svm_accel_decide.sv
module svm_accel_decide
  import svm_accel_pkg::*;
#(
  parameter int NUM_CLASSES = 8,
  parameter int CLS_W       = 3,
  parameter int VOTE_W      = 8,
  parameter int ACC_W       = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            ctl,
  input  logic             schemeSel,
  input  logic [ACC_W-1:0] acc,
  input  logic [CLS_W-1:0] posCls,
  input  logic [CLS_W-1:0] negCls,
  output logic             resultValid,
  output logic [CLS_W-1:0] resultClass
);
  localparam int TOT_W = VOTE_W + CLS_W;

  logic [VOTE_W-1:0]       votes [NUM_CLASSES];
  logic signed [ACC_W-1:0] bestScore, accS;
  logic [CLS_W-1:0]        bestCls, voteCls, voteWin;
  logic                    haveBest, replace;
  logic [TOT_W-1:0]        voteTotal;

  assign accS    = signed'(acc);
  assign replace = !haveBest || (accS > bestScore) ||
                   (accS == bestScore && posCls < bestCls);
  assign voteCls = accS[ACC_W-1] ? negCls : posCls;

  always_comb begin
    voteWin   = '0;
    voteTotal = '0;
    for (int c = 0; c < NUM_CLASSES; c++) begin
      voteTotal += TOT_W'(votes[c]);
      if (votes[c] > votes[voteWin]) voteWin = CLS_W'(c);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clear) begin
      for (int c = 0; c < NUM_CLASSES; c++) votes[c] <= '0;
      haveBest  <= 1'b0;
      bestScore <= '0;
      bestCls   <= '0;
    end else if (ctl.score) begin
      if (schemeSel) begin
        if (int'(voteCls) < NUM_CLASSES) votes[voteCls] <= votes[voteCls] + 1'b1;
      end else if (replace) begin
        haveBest  <= 1'b1;
        bestScore <= accS;
        bestCls   <= posCls;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultValid <= 1'b0;
      resultClass <= '0;
    end else if (ctl.decide) begin
      resultValid <= 1'b1;
      resultClass <= schemeSel ? voteWin : bestCls;
    end else if (ctl.load) begin
      resultValid <= 1'b0;
    end
  end

  a_r10_valid_after_decide: assert property (@(posedge clk) disable iff (!rstN)
    ctl.decide |=> resultValid);
  a_r10_result_held: assert property (@(posedge clk) disable iff (!rstN)
    resultValid && !ctl.load && !ctl.decide |=> resultValid && $stable(resultClass));
  a_r9_one_vote_per_score: assert property (@(posedge clk) disable iff (!rstN)
    ctl.score && schemeSel |=> voteTotal == $past(voteTotal) + 1'b1);
endmodule

// File: rtl/svm_accel.sv
module svm_accel
  import svm_accel_pkg::*;
#(
  parameter int NUM_CLASSES = 8,
  parameter int VOTE_W      = 8,
  parameter int CLS_W       = $clog2(NUM_CLASSES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  output logic             cmdReady,
  input  logic [1:0]       cmdOp,
  input  logic [31:0]      cmdFeat,
  input  logic [31:0]      cmdWeight,
  input  logic [1:0]       precSel,
  input  logic             schemeSel,
  output logic             resultValid,
  output logic [CLS_W-1:0] resultClass,
  output logic [31:0]      accValue
);
  localparam int ACC_W = 32;

  ctrl_t            ctl;
  logic [CLS_W-1:0] posCls, negCls;

  svm_accel_ctrl u_ctrl (
    .clk, .rstN, .cmdValid, .cmdOp, .precSel, .cmdReady, .ctl
  );

  svm_accel_dp #(.ACC_W(ACC_W), .CLS_W(CLS_W)) u_dp (
    .clk, .rstN, .ctl, .cmdFeat, .cmdWeight,
    .acc(accValue), .posCls, .negCls
  );

  svm_accel_decide #(
    .NUM_CLASSES(NUM_CLASSES), .CLS_W(CLS_W), .VOTE_W(VOTE_W), .ACC_W(ACC_W)
  ) u_decide (
    .clk, .rstN, .ctl, .schemeSel, .acc(accValue), .posCls, .negCls,
    .resultValid, .resultClass
  );
endmodule

// File: tb/svm_accel_test.sv
module svm_accel_test;
  logic        clk = 1'b0, rstN = 1'b0;
  logic        cmdValid = 1'b0, cmdReady, schemeSel = 1'b0, resultValid;
  logic [1:0]  cmdOp = 2'd0, precSel = 2'd0;
  logic [31:0] cmdFeat = '0, cmdWeight = '0, accValue;
  logic [2:0]  resultClass;

  int vecs = 0, errs = 0, lastBusy = 0;
  logic [31:0] expAcc;

  always #10 clk = ~clk;

  svm_accel uut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mac4(logic [31:0] f, logic [31:0] w);
    logic [31:0] s = '0;
    for (int i = 0; i < 8; i++) begin
      int a = $signed(f[4*i +: 4]);
      int b = $signed(w[4*i +: 4]);
      s += 32'(a * b);
    end
    return s;
  endfunction

  function automatic logic [31:0] mac8(logic [31:0] f, logic [31:0] w);
    logic [31:0] s = '0;
    for (int i = 0; i < 2; i++) begin
      int a = $signed(f[8*i +: 8]);
      int b = $signed(w[8*i +: 8]);
      s += 32'(a * b);
    end
    return s;
  endfunction

  function automatic logic [31:0] mac16(logic [31:0] f, logic [31:0] w);
    int a = $signed(f[15:0]);
    int b = $signed(w[15:0]);
    return 32'(a * b);
  endfunction

  function automatic logic [31:0] macExp(logic [1:0] p, logic [31:0] f, logic [31:0] w);
    if (p[1]) return mac16(f, w);
    if (p[0]) return mac8(f, w);
    return mac4(f, w);
  endfunction

  task automatic send(logic [1:0] op, logic [31:0] f, logic [31:0] w);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdFeat = f; cmdWeight = w;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    lastBusy = 0;
    while (!cmdReady) begin
      lastBusy++;
      @(negedge clk);
    end
  endtask

  task automatic doMac(logic [31:0] f, logic [31:0] w);
    send(2'd1, f, w);
    expAcc += macExp(precSel, f, w);
  endtask

  task automatic doClear();
    send(2'd0, '0, '0);
    expAcc = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; vecs++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int scores [8];
    int votes [8];
    int best;
    logic [31:0] f, w;
    void'($urandom(32'd7301));
    expAcc = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset ready", 32'(cmdReady), 32'd1);
    check("R10 reset valid", 32'(resultValid), 32'd0);
    check("R5 reset acc", accValue, 32'd0);

    // R2 R3 R4 random products at each precision, R1 busy length
    for (int p = 0; p < 3; p++) begin
      precSel = 2'(p);
      doClear();
      check("R6 clear acc", accValue, 32'd0);
      for (int n = 0; n < 25; n++) begin
        f = $urandom; w = $urandom;
        doMac(f, w);
        check(p == 0 ? "R2 mac4" : (p == 1 ? "R3 mac8" : "R4 mac16"), accValue, expAcc);
        check("R1 busy cycles", 32'(lastBusy), p == 2 ? 32'd2 : 32'd1);
      end
    end

    // directed extremes
    precSel = 2'd0; doClear();
    doMac(32'h88888888, 32'h88888888);
    check("R2 min nibbles", accValue, 32'd512);
    precSel = 2'd1; doClear();
    doMac(32'h12348080, 32'hFFFF8080);
    check("R3 min bytes upper ignored", accValue, 32'd32768);
    precSel = 2'd3; doClear();
    doMac(32'h00008000, 32'h00007FFF);
    check("R4 mixed sign", accValue, 32'hC0008000);
    doClear();
    for (int n = 0; n < 4; n++) doMac(32'h00008000, 32'h00008000);
    check("R5 wrap", accValue, 32'd0);

    // R11 command offered while busy is dropped
    precSel = 2'd0; doClear();
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 2'd1; cmdFeat = 32'h11111111; cmdWeight = 32'h11111111;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdOp = 2'd0;
    check("R11 busy ready", 32'(cmdReady), 32'd0);
    @(negedge clk);
    cmdValid = 1'b0;
    @(negedge clk);
    check("R11 clear while busy ignored", accValue, 32'd8);

    // R8 one-vs-rest random
    schemeSel = 1'b0; precSel = 2'd1; doClear();
    best = -1;
    for (int c = 0; c < 6; c++) begin
      int nm = 1 + int'($urandom % 3);
      for (int k = 0; k < nm; k++) doMac($urandom, $urandom);
      scores[c] = int'(expAcc);
      send(2'd2, 32'(c), '0);
      expAcc = '0;
      check("R7 acc zero after score", accValue, 32'd0);
      if (best < 0 || scores[c] > scores[best]) best = c;
    end
    send(2'd3, '0, '0);
    check("R10 valid after decide", 32'(resultValid), 32'd1);
    check("R8 argmax", 32'(resultClass), 32'(best));

    // R8 tie to lower index, scored in descending order
    doClear();
    doMac(32'h00000505, 32'h00000303); send(2'd2, 32'd3, '0); expAcc = '0;
    doMac(32'h00000505, 32'h00000303); send(2'd2, 32'd1, '0); expAcc = '0;
    doMac(32'h00000101, 32'h00000101); send(2'd2, 32'd0, '0); expAcc = '0;
    send(2'd3, '0, '0);
    check("R8 tie lowest index", 32'(resultClass), 32'd1);

    // R9 one-vs-one random over five classes
    schemeSel = 1'b1; precSel = 2'd0; doClear();
    for (int c = 0; c < 8; c++) votes[c] = 0;
    for (int i = 0; i < 5; i++)
      for (int j = i + 1; j < 5; j++) begin
        int nm = 1 + int'($urandom % 2);
        for (int k = 0; k < nm; k++) doMac($urandom, $urandom);
        if (expAcc[31]) votes[j]++; else votes[i]++;
        send(2'd2, {24'd0, 4'(j), 4'(i)}, '0);
        expAcc = '0;
      end
    best = 0;
    for (int c = 1; c < 8; c++) if (votes[c] > votes[best]) best = c;
    send(2'd3, '0, '0);
    check("R9 vote winner", 32'(resultClass), 32'(best));

    // R10 held across idle cycles, dropped on next command
    repeat (3) @(negedge clk);
    check("R10 valid held", 32'(resultValid), 32'd1);
    check("R10 class held", 32'(resultClass), 32'(best));
    doClear();
    check("R10 valid dropped", 32'(resultValid), 32'd0);

    // R6 votes cleared: single zero-score vote to class 6
    send(2'd2, {24'd0, 4'd7, 4'd6}, '0);
    send(2'd3, '0, '0);
    check("R6 votes cleared / R9 zero to positive", 32'(resultClass), 32'd6);

    // R9 negative score votes for negative class, ties to lower index
    doClear();
    doMac(32'h00000007, 32'h00000009);   // -7*7 = -49
    send(2'd2, {24'd0, 4'd4, 4'd2}, '0); expAcc = '0;
    send(2'd2, {24'd0, 4'd0, 4'd3}, '0);
    send(2'd3, '0, '0);
    check("R9 negative and tie", 32'(resultClass), 32'd3);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule